// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a cycle-level model of a register-to-register synchronous static RAM with a two-bit burst address counter. Every address, data and control input is sampled on the rising clock edge. Two address strobes can open an access: one driven by a processor and one by a memory controller. With neither strobe asserted, an advance input either steps the burst to its next address or holds it. The burst steps through the four words of an aligned group in either a wrapping linear order or an XOR (interleaved) order. A static mode input selects the order.

Writes are byte-lane masked and self-timed from the sampling edge. Read data passes through an output register, so it reaches the data pins one edge later than it would in a flow-through part. The output enable is asynchronous and is applied after that register. The data bus is split into a write-data input, a read-data output and a drive-enable output. Read data is 0 whenever the drive-enable output is low.

A system can use the block as a burst cache data RAM. It can also run it as a plain pipelined SRAM: the processor strobe is held high, the controller strobe is held low, and advance is held high.

Top module: `sram_burst_pipe`

## Requirements
- R1: The device is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. These are looked at only when a strobe opens an access. A strobe start without full selection is a deselect: the open burst ends, and later advance cycles read or write nothing until the next start.
- R2: A processor strobe (`cpu_as_n`=0) seen while `ce1_n`=1 is ignored and causes no deselect. The cycle behaves as an advance/hold cycle of the open burst.
- R3: A selected processor-strobe start is always a read at `addr`, whatever `gw_n`, `we_n` and `bw_n` hold. It has priority over the controller strobe.
- R4: A selected controller-strobe start (`cpu_as_n`=1, `ctl_as_n`=0) reads or writes at `addr` according to the write controls, and opens a burst based at `addr`.
- R5: In a cycle with both strobes high and `adv_n`=0, the burst step count n advances by one, modulo 4. The access address keeps the upper bits of the base address. Its two low bits are (base+n) mod 4 when `ilv_mode`=0, and base XOR n when `ilv_mode`=1.
- R6: In a cycle with both strobes high and `adv_n`=1, the address is held. A write in such a cycle is applied at the current burst address.
- R7: Byte lane i is bits [9i+8:9i] of the data word. `gw_n`=0 writes all lanes. Otherwise, when `we_n`=0, lane i is written if `bw_n[i]`=0. A cycle that writes no lane is a read.
- R8: Read data for an access sampled at edge N is driven on `rdata` after edge N+1 and stays until edge N+2.
- R9: `oe_n` is not clocked. While it is 1, `rdata_en`=0 and `rdata`=0. Lowering it restores the pending read data without a clock edge.
- R10: A deselect cycle or a write cycle sampled at edge N leaves `rdata_en` low after edge N+1.
- R11: With `cpu_as_n`=1, `ctl_as_n`=0 and `adv_n`=1 held, every cycle is an independent access at a new external address.
- R12: After reset, `rdata_en` is 0, no burst is open, and advance cycles produce no data until a strobe start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset of control state |
| addr | input | ADDR_W | External word address |
| cpu_as_n | input | 1 | Processor address strobe, active low |
| ctl_as_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce1_n | input | 1 | Chip select, active low (also gates the processor strobe) |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Write all lanes, active low |
| we_n | input | 1 | Lane-masked write enable, active low |
| bw_n | input | LANES | Per-lane write select, active low |
| ilv_mode | input | 1 | Burst order: 0 linear wrap, 1 interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| rdata_en | output | 1 | Read bus drive enable |

## Verification
Checks on every cycle cover the following. A strobe start loads the burst base. A deselect ends the burst. A hold cycle keeps the step count. A selected processor start never writes. The output register holds data only when a read entered the pipeline one edge earlier. A deselect or a write is never followed by a driven bus two edges later. The bench scenarios are the only evidence for the rest: the data values and the two wrap orders, lane masking, writes during hold and advance cycles, the ignored processor strobe, and the asynchronous effect of the output enable.

// File: rtl/sbp_pkg.sv
package sbp_pkg;

  typedef enum logic [1:0] {
    CYC_CONT  = 2'd0,
    CYC_START = 2'd1,
    CYC_DESEL = 2'd2
  } cyc_kind_t;

  // Low two address bits of step n from burst base b.
  function automatic logic [1:0] burst_low(input logic [1:0] b,
                                           input logic [1:0] n,
                                           input logic       ilv);
    return ilv ? (b ^ n) : (b + n);
  endfunction

endpackage

// File: rtl/sbp_decode.sv
module sbp_decode #(
  parameter int LANES = 4
) (
  input  logic              cpu_as_n,
  input  logic              ctl_as_n,
  input  logic              ce1_n,
  input  logic              ce2,
  input  logic              ce3_n,
  input  logic              gw_n,
  input  logic              we_n,
  input  logic [LANES-1:0]  bw_n,
  output sbp_pkg::cyc_kind_t kind,
  output logic [LANES-1:0]  lane_we
);
  import sbp_pkg::*;

  logic cpu_take;
  logic selected;
  logic [LANES-1:0] ctl_mask;

  assign cpu_take = !cpu_as_n && !ce1_n;
  assign selected = !ce1_n && ce2 && !ce3_n;

  always_comb begin
    if (!gw_n)      ctl_mask = '1;
    else if (!we_n) ctl_mask = ~bw_n;
    else            ctl_mask = '0;
  end

  always_comb begin
    if (cpu_take || !ctl_as_n) kind = selected ? CYC_START : CYC_DESEL;
    else                       kind = CYC_CONT;
  end

  assign lane_we = cpu_take ? '0 : ctl_mask;

endmodule

// File: rtl/sbp_burst.sv
module sbp_burst #(
  parameter int ADDR_W = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  sbp_pkg::cyc_kind_t kind,
  input  logic               adv_n,
  input  logic               ilv_mode,
  input  logic [ADDR_W-1:0]  addr,
  output logic [ADDR_W-1:0]  eff_addr,
  output logic               go
);
  import sbp_pkg::*;

  logic              active;
  logic [ADDR_W-1:0] base;
  logic [1:0]        cnt;
  logic [1:0]        nxt;

  assign nxt = adv_n ? cnt : cnt + 2'd1;
  assign go  = (kind == CYC_START) || ((kind == CYC_CONT) && active);

  always_comb begin
    if (kind == CYC_START) eff_addr = addr;
    else eff_addr = {base[ADDR_W-1:2], burst_low(base[1:0], nxt, ilv_mode)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      base   <= '0;
      cnt    <= '0;
    end else begin
      case (kind)
        CYC_START: begin
          active <= 1'b1;
          base   <= addr;
          cnt    <= '0;
        end
        CYC_DESEL: active <= 1'b0;
        default:   if (active) cnt <= nxt;
      endcase
    end
  end

  // R4
  start_loads_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_START) |=> (active && base == $past(addr)));

  // R1
  desel_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == CYC_DESEL) |=> !active);

  // R6
  hold_keeps_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && kind == CYC_CONT && adv_n) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/sbp_array.sv
module sbp_array #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go,
  input  logic [LANES-1:0]        lane_we,
  input  logic [ADDR_W-1:0]       eff_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_vld
);
  localparam int DEPTH = 1 << ADDR_W;

  logic any_we;
  assign any_we = |lane_we;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (go && lane_we[i]) mem[eff_addr] <= wdata[i*LANE_W +: LANE_W];
      if (go && !any_we)    rd_data[i*LANE_W +: LANE_W] <= mem[eff_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= go && !any_we;
  end

endmodule

// File: rtl/sbp_outq.sv
module sbp_outq #(
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] p1_data,
  input  logic          p1_vld,
  input  logic          oe_n,
  output logic [DW-1:0] rdata,
  output logic          rdata_en
);
  logic [DW-1:0] q_data;
  logic          q_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_vld <= 1'b0;
    else        q_vld <= p1_vld;
  end

  always_ff @(posedge clk) begin
    if (p1_vld) q_data <= p1_data;
  end

  assign rdata_en = q_vld && !oe_n;
  assign rdata    = rdata_en ? q_data : '0;

  // R8
  outreg_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_vld |-> $past(p1_vld));

endmodule

// File: rtl/sram_burst_pipe.sv
module sram_burst_pipe #(
  parameter int ADDR_W = 9,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cpu_as_n,
  input  logic                    ctl_as_n,
  input  logic                    adv_n,
  input  logic                    ce1_n,
  input  logic                    ce2,
  input  logic                    ce3_n,
  input  logic                    gw_n,
  input  logic                    we_n,
  input  logic [LANES-1:0]        bw_n,
  input  logic                    ilv_mode,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] wdata,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic                    rdata_en
);
  import sbp_pkg::*;

  localparam int DW = LANES * LANE_W;

  cyc_kind_t         kind;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] eff_addr;
  logic              go;
  logic [DW-1:0]     p1_data;
  logic              p1_vld;

  sbp_decode #(.LANES(LANES)) u_dec (
    .cpu_as_n(cpu_as_n), .ctl_as_n(ctl_as_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .gw_n(gw_n), .we_n(we_n), .bw_n(bw_n),
    .kind(kind), .lane_we(lane_we)
  );

  sbp_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .kind(kind), .adv_n(adv_n),
    .ilv_mode(ilv_mode), .addr(addr), .eff_addr(eff_addr), .go(go)
  );

  sbp_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .go(go), .lane_we(lane_we),
    .eff_addr(eff_addr), .wdata(wdata), .rd_data(p1_data), .rd_vld(p1_vld)
  );

  sbp_outq #(.DW(DW)) u_outq (
    .clk(clk), .rst_n(rst_n), .p1_data(p1_data), .p1_vld(p1_vld),
    .oe_n(oe_n), .rdata(rdata), .rdata_en(rdata_en)
  );

  // R3
  cpu_start_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_as_n && !ce1_n) |-> (lane_we == '0));

  // R10
  no_drive_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == CYC_DESEL) || (go && |lane_we)) |=> ##1 !rdata_en);

endmodule

// File: tb/test_sram_burst_pipe.sv
`timescale 1ns/1ps
module test_sram_burst_pipe;
  localparam int AW = 9;
  localparam int LN = 4;
  localparam int LW = 9;
  localparam int DW = LN * LW;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic cpu_as_n = 1'b1, ctl_as_n = 1'b1, adv_n = 1'b1;
  logic ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
  logic gw_n = 1'b1, we_n = 1'b1;
  logic [LN-1:0] bw_n = '1;
  logic ilv_mode = 1'b0, oe_n = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic rdata_en;

  int checks = 0;
  int fails = 0;
  int seed_val;

  always #2.5 clk = ~clk;

  sram_burst_pipe #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_sram_burst_pipe (
    .clk(clk), .rst_n(rst_n), .addr(addr), .cpu_as_n(cpu_as_n),
    .ctl_as_n(ctl_as_n), .adv_n(adv_n), .ce1_n(ce1_n), .ce2(ce2),
    .ce3_n(ce3_n), .gw_n(gw_n), .we_n(we_n), .bw_n(bw_n),
    .ilv_mode(ilv_mode), .oe_n(oe_n), .wdata(wdata), .rdata(rdata),
    .rdata_en(rdata_en)
  );

  // Reference model state
  logic [DW-1:0] m_mem [DEPTH];
  logic          m_act;
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  logic          m_p1v, m_qv;
  logic [DW-1:0] m_p1d, m_qd;

  function automatic logic [1:0] ord(input logic [1:0] b, input logic [1:0] n,
                                     input logic ilv);
    if (ilv) return b ^ n;
    return 2'(b + n);
  endfunction

  function automatic logic [DW-1:0] pat(input int a);
    return {4'(a), 32'(a * 32'h9E37_79B1 + 32'h1234_5678)};
  endfunction

  task automatic model_reset();
    m_act = 1'b0; m_base = '0; m_cnt = '0;
    m_p1v = 1'b0; m_qv = 1'b0; m_p1d = '0; m_qd = '0;
  endtask

  task automatic model_edge();
    logic sel, cpu_take, go, start, desel;
    logic [LN-1:0] mask;
    logic [AW-1:0] eff;
    logic [1:0] n;
    m_qv = m_p1v;
    if (m_p1v) m_qd = m_p1d;
    sel = !ce1_n && ce2 && !ce3_n;
    cpu_take = !cpu_as_n && !ce1_n;
    start = (cpu_take || !ctl_as_n) && sel;
    desel = (cpu_take || !ctl_as_n) && !sel;
    if (cpu_take) mask = '0;
    else if (!gw_n) mask = '1;
    else if (!we_n) mask = ~bw_n;
    else mask = '0;
    go = 1'b0;
    eff = '0;
    if (desel) m_act = 1'b0;
    else if (start) begin
      m_act = 1'b1; m_base = addr; m_cnt = '0; eff = addr; go = 1'b1;
    end else if (m_act) begin
      n = adv_n ? m_cnt : 2'(m_cnt + 2'd1);
      m_cnt = n;
      eff = {m_base[AW-1:2], ord(m_base[1:0], n, ilv_mode)};
      go = 1'b1;
    end
    if (go && mask != '0) begin
      for (int i = 0; i < LN; i++)
        if (mask[i]) m_mem[eff][i*LW +: LW] = wdata[i*LW +: LW];
      m_p1v = 1'b0;
    end else if (go) begin
      m_p1v = 1'b1;
      m_p1d = m_mem[eff];
    end else m_p1v = 1'b0;
  endtask

  task automatic check_out(input string tag);
    logic          e_en;
    logic [DW-1:0] e_d;
    e_en = m_qv && !oe_n;
    e_d  = e_en ? m_qd : '0;
    checks++;
    if (rdata_en !== e_en || rdata !== e_d) begin
      fails++;
      $display("FAIL %s: rdata_en=%0b rdata=%h expected rdata_en=%0b rdata=%h",
               tag, rdata_en, rdata, e_en, e_d);
    end
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out(tag);
  endtask

  task automatic idle_inputs();
    cpu_as_n = 1'b1; ctl_as_n = 1'b1; adv_n = 1'b1;
    ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    gw_n = 1'b1; we_n = 1'b1; bw_n = '1; oe_n = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete, got hang expected finish");
    finish_run();
  end

  initial begin
    seed_val = $urandom(32'h5EED_0042);
    model_reset();
    idle_inputs();
    repeat (3) @(negedge clk);
    check_out("R12 reset");
    rst_n = 1'b1;
    // R12: advance cycles with no open burst give no data
    adv_n = 1'b0;
    repeat (3) step("R12 no burst after reset");

    // R11: non-burst fill of every word, one address per clock
    idle_inputs(); ctl_as_n = 1'b0; gw_n = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      addr = AW'(a); wdata = pat(a);
      step("R11 fill / R10 write no drive");
    end
    gw_n = 1'b1;
    for (int a = 0; a < 8; a++) begin
      addr = AW'(a * 7);
      step("R11 R8 non-burst read");
    end
    idle_inputs(); step("R8 drain"); step("R8 drain");

    // R3: processor start with write controls active reads only
    cpu_as_n = 1'b0; gw_n = 1'b0; we_n = 1'b0; bw_n = '0;
    addr = AW'(16); wdata = '1;
    step("R3 cpu start reads");
    idle_inputs(); ctl_as_n = 1'b0; addr = AW'(16);
    step("R3 data unchanged");
    idle_inputs(); step("R3 read out"); step("R3 drain");

    // R5: linear burst from low bits 01
    ilv_mode = 1'b0;
    cpu_as_n = 1'b0; addr = AW'(9'h021); step("R5 linear start");
    cpu_as_n = 1'b1; adv_n = 1'b0;
    repeat (4) step("R5 linear advance");
    // R6: hold
    adv_n = 1'b1; repeat (2) step("R6 hold read");
    idle_inputs(); ctl_as_n = 1'b0; ce2 = 1'b0; step("R1 deselect ce2");
    idle_inputs(); step("R10 deselect drains");
    adv_n = 1'b0; repeat (2) step("R1 closed burst silent");

    // R5: interleaved burst from low bits 10
    idle_inputs(); ilv_mode = 1'b1;
    cpu_as_n = 1'b0; addr = AW'(9'h0A2); step("R5 ilv start");
    cpu_as_n = 1'b1; adv_n = 1'b0;
    repeat (4) step("R5 ilv advance");
    // R2: processor strobe blocked by ce1_n high continues burst
    cpu_as_n = 1'b0; ce1_n = 1'b1; adv_n = 1'b0;
    step("R2 blocked strobe continues");
    cpu_as_n = 1'b1; ce1_n = 1'b0; step("R2 after block");
    // R1: processor start with ce3_n high deselects
    cpu_as_n = 1'b0; ce3_n = 1'b1; step("R1 deselect ce3");
    idle_inputs(); adv_n = 1'b0; step("R1 no data"); step("R1 no data");
    ilv_mode = 1'b0;

    // R4 / R7: controller start write lanes 1 and 3 only
    idle_inputs(); ctl_as_n = 1'b0; we_n = 1'b0; bw_n = 4'b0101;
    addr = AW'(9'h040); wdata = 36'hA_BCDE_F012;
    step("R4 R7 lane write");
    // R6: hold write lands on same address, then advance write
    ctl_as_n = 1'b1; we_n = 1'b1; gw_n = 1'b0; adv_n = 1'b1;
    wdata = 36'h1_2345_6789; step("R6 hold write");
    adv_n = 1'b0; wdata = 36'h9_8765_4321; step("R6 advance write");
    idle_inputs(); ctl_as_n = 1'b0;
    for (int a = 'h40; a < 'h44; a++) begin
      addr = AW'(a); step("R4 R7 R6 readback");
    end
    // R7: we_n low with no lanes selected is a read
    we_n = 1'b0; bw_n = '1; addr = AW'(9'h041); wdata = '0;
    step("R7 empty mask reads");
    idle_inputs(); step("R7 out"); step("R7 drain");

    // R9: asynchronous output enable
    cpu_as_n = 1'b0; addr = AW'(5); step("R9 start");
    idle_inputs(); adv_n = 1'b1; ctl_as_n = 1'b1;
    cpu_as_n = 1'b1; step("R9 hold");
    oe_n = 1'b1; #0.5;
    check_out("R9 oe high no drive");
    oe_n = 1'b0; #0.5;
    check_out("R9 oe low drives");
    checks++;
    if (rdata_en !== 1'b1) begin
      fails++;
      $display("FAIL R9: rdata_en=%0b expected 1", rdata_en);
    end
    @(negedge clk);

    // Random mix
    for (int c = 0; c < 3000; c++) begin
      if (c % 600 == 0) ilv_mode = ~ilv_mode;
      cpu_as_n = ($urandom % 100) >= 15;
      ctl_as_n = ($urandom % 100) >= 20;
      adv_n    = $urandom % 2;
      ce1_n    = ($urandom % 100) >= 90;
      ce2      = ($urandom % 100) < 95;
      ce3_n    = ($urandom % 100) >= 95;
      gw_n     = ($urandom % 100) >= 15;
      we_n     = ($urandom % 100) >= 30;
      bw_n     = LN'($urandom);
      oe_n     = ($urandom % 100) >= 85;
      addr     = AW'($urandom);
      wdata    = {4'($urandom), 32'($urandom)};
      step("R7 random mix");
    end
    idle_inputs();
    step("R10 end"); step("R10 end");
    finish_run();
  end

endmodule